// File: doc/BRIEF.md
# Per-Cycle Selectable Output Limiter

This block is the final stage of a filter datapath. Each signed 16-bit result that arrives with a valid flag is clamped to a programmable range and then registered. A bank of sixteen bound pairs holds the ranges. Each pair has an upper and a lower bound.

A 4-bit select input picks the active pair on every clock cycle. Several interleaved data streams can therefore share the limiter, and each stream uses its own range. A global enable turns the clamp off, and the sample then passes through unchanged. Bounds are loaded through a simple write port that takes an address, data and a strobe. Software must load every upper bound strictly greater than its lower bound.

Top module: `range_clamp`

## Requirements
- R1: After reset, out_valid and out_data are 0. Every pair holds upper = 0x7FFF and lower = 0x8000, so with limiting on, any input passes unchanged.
- R2: out_valid equals in_valid delayed by one clock. out_data changes only in the cycle after an accepted sample, and it holds its value while in_valid is low.
- R3: With lim_en = 1, an input less than the selected lower bound produces the lower bound.
- R4: With lim_en = 1, an input greater than the selected upper bound produces the upper bound.
- R5: With lim_en = 1, an input between the bounds passes unchanged, and so does an input equal to either bound.
- R6: With lim_en = 0, the input passes unchanged, whatever the selected bounds are.
- R7: A sel value of k uses pair k. sel may change on every cycle, and each sample is clamped with the pair selected in its own cycle.
- R8: A write with wr_en = 1 loads pair wr_addr. wr_data[31:16] is the signed upper bound and wr_data[15:0] is the signed lower bound. No other pair changes.
- R9: If a pair is written in the same cycle that it is selected, that cycle's sample uses the old bounds. The new bounds apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bound write strobe |
| wr_addr | input | 4 | Index of the pair to write |
| wr_data | input | 32 | {upper[15:0], lower[15:0]}, both signed |
| lim_en | input | 1 | 1 = clamp, 0 = pass through |
| sel | input | 4 | Pair used for this cycle's sample |
| in_valid | input | 1 | Input sample is valid |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample is valid |
| out_data | output | 16 | Registered, clamped signed sample |

## Verification
The hardest case to reach is the collision in R9. A pair is rewritten in the same cycle that a sample selects it. The stimulus must put the write strobe and the sample on the same edge, and then follow with a second sample on the next edge using the same select. That shows the old range applying first and the new range applying after it.

Per-cycle switching (R7) is reached the same way. Back-to-back samples alternate between two pairs with different ranges, and no idle cycle is placed between them.

// File: rtl/range_clamp.sv
module range_clamp #(
  parameter int DW   = 16,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_addr,
  input  logic [2*DW-1:0] wr_data,
  input  logic            lim_en,
  input  logic [SELW-1:0] sel,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  output logic            out_valid,
  output logic [DW-1:0]   out_data
);
  localparam int NPAIR = 1 << SELW;
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic [2*DW-1:0] bank [NPAIR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAIR; i++) bank[i] <= {MAXV, MINV};
    end else if (wr_en) begin
      bank[wr_addr] <= wr_data;
    end
  end

  logic signed [DW-1:0] hi, lo, din, clamped;
  assign hi  = bank[sel][2*DW-1:DW];
  assign lo  = bank[sel][DW-1:0];
  assign din = in_data;
  assign clamped = (din < lo) ? lo : (din > hi) ? hi : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= lim_en ? clamped : in_data;
    end
  end
endmodule

module range_clamp_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lim_en,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_data));
  // R6
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lim_en) |=> (out_data == $past(in_data)));
endmodule

bind range_clamp range_clamp_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lim_en(lim_en), .in_valid(in_valid),
  .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_range_clamp.sv
module sim_range_clamp;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, lim_en = 0, in_valid = 0;
  logic [3:0]  wr_addr = 0, sel = 0;
  logic [31:0] wr_data = 0;
  logic [15:0] in_data = 0;
  logic        out_valid;
  logic [15:0] out_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  range_clamp u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lim_en(lim_en), .sel(sel), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, $signed(got), $signed(exp));
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic signed [15:0] hi, input logic signed [15:0] lo);
    wr_en = 1; wr_addr = a; wr_data = {hi, lo};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send(string req, input logic [3:0] s, input logic en,
                      input logic signed [15:0] d, input logic signed [15:0] exp);
    in_valid = 1; sel = s; lim_en = en; in_data = d;
    @(negedge clk);
    chk(req, {15'd0, out_valid}, 16'd1);
    chk(req, out_data, exp);
  endtask

  task automatic idle();
    in_valid = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", {15'd0, out_valid}, 16'd0);
    chk("R1", out_data, 16'd0);
    send("R1", 4'd0,  1, 16'sh7FFF, 16'sh7FFF);
    send("R1", 4'd15, 1, 16'sh8000, 16'sh8000);
    idle();
  endtask

  task automatic t_clamp();
    wr(4'd3, 16'sd100, -16'sd50);
    send("R4", 4'd3, 1, 16'sd200, 16'sd100);
    send("R3", 4'd3, 1, -16'sd300, -16'sd50);
    send("R5", 4'd3, 1, 16'sd100, 16'sd100);
    send("R5", 4'd3, 1, -16'sd50, -16'sd50);
    send("R5", 4'd3, 1, 16'sd7, 16'sd7);
    send("R8", 4'd4, 1, 16'sd200, 16'sd200);
    idle();
  endtask

  task automatic t_bypass();
    send("R6", 4'd3, 0, 16'sd200, 16'sd200);
    send("R6", 4'd3, 0, -16'sd999, -16'sd999);
    idle();
  endtask

  task automatic t_switch();
    wr(4'd5, 16'sd10, 16'sd0);
    send("R7", 4'd3, 1, 16'sd50, 16'sd50);
    send("R7", 4'd5, 1, 16'sd50, 16'sd10);
    send("R7", 4'd3, 1, -16'sd60, -16'sd50);
    send("R7", 4'd5, 1, -16'sd60, 16'sd0);
    idle();
  endtask

  task automatic t_hold();
    send("R2", 4'd3, 1, 16'sd42, 16'sd42);
    in_valid = 0; in_data = -16'sd999;
    @(negedge clk);
    chk("R2", {15'd0, out_valid}, 16'd0);
    chk("R2", out_data, 16'sd42);
  endtask

  task automatic t_collide();
    wr_en = 1; wr_addr = 4'd6; wr_data = {16'sd5, -16'sd5};
    send("R9", 4'd6, 1, 16'sd20, 16'sd20);
    wr_en = 0;
    send("R9", 4'd6, 1, 16'sd20, 16'sd5);
    idle();
  endtask

  task automatic t_signed();
    wr(4'd7, -16'sd10, -16'sd20);
    send("R8", 4'd7, 1, 16'sd0, -16'sd10);
    send("R8", 4'd7, 1, -16'sd100, -16'sd20);
    send("R8", 4'd6, 1, -16'sd9, -16'sd5);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clamp();
    t_bypass();
    t_switch();
    t_hold();
    t_collide();
    t_signed();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule